// File: doc/BRIEF.md
# Supply-Monitor Reset Controller

This block produces the active-low chip reset from a digital "supply is above threshold" bit supplied by an analog comparator. Whenever the monitor is switched on and the supply drops below threshold, reset is driven low. Reset is released only after the supply, and every other reset cause, has been quiet for a fixed settling interval. The interval is set by a clock-frequency parameter and a time parameter. The supply bit passes through a two-stage synchroniser and a short deglitch filter before it is used. An asynchronous external reset request goes through the same synchroniser.

A small reset-cause register is readable by software. Bit 1 is the power-type flag: cold start, supply dip or software force. Bit 0 is the external flag. Every cause restarts code at the same address, so these flags are the only record of why reset happened. If software writes a 1 into bit 1, a complete power-type reset sequence runs. A monitor-enable pin turns supply checking on and off. A build parameter can instead tie the monitor permanently on. The synchronous active-high `rst_i` input is the cold-start pulse from the analog power-up cell. It is handled as a power-type cause.

Top module: `smrc_top`

## Requirements
- R1: While `rst_i` is high, `rst_n_o` is 0 and `flags_o` reads 0x02 (bit 1 = power-type flag, bit 0 = external flag, bits 7..2 always 0).
- R2: `rst_n_o` rises exactly TMO clock edges after the last edge at which any reset cause is seen, where TMO = CLK_HZ * TIMEOUT_US / 1e6. After a cold start with the supply already good, it rises TMO + FILT_LEN + SYNC_STAGES - 1 edges after the first edge that samples `rst_i` low.
- R3: With the monitor on, if `sup_good_i` is low for at least FILT_LEN cycles starting at edge k, `rst_n_o` falls after edge k + SYNC_STAGES + FILT_LEN. If the supply returns at edge r, the last cause is at edge r + SYNC_STAGES - 1 + FILT_LEN.
- R4: A low pulse on `sup_good_i` shorter than FILT_LEN cycles has no effect: `rst_n_o` stays 1 and `flags_o` is unchanged.
- R5: A new reset cause seen while the settling interval is running restarts the count from zero.
- R6: Every power-type cause (cold start, supply dip, software force) sets bit 1 and clears bit 0, so exactly one flag bit is set at any time after reset.
- R7: An external request high from edge k to edge d holds reset. `rst_n_o` falls after edge k + SYNC_STAGES, the last cause is at edge d + SYNC_STAGES - 1, and `flags_o` becomes 0x01.
- R8: A write with `wr_data_i[1]` = 1 sampled at edge k drives `rst_n_o` low after edge k, sets `flags_o` to 0x02, and releases reset after edge k + TMO.
- R9: A write with `wr_data_i[1]` = 0 has no effect: reset stays released and `flags_o` is unchanged, whatever the other data bits hold.
- R10: An external request during a power-type hold leaves `flags_o` at 0x02 but still extends the hold. A power-type cause during an external hold changes `flags_o` to 0x02.
- R11: With MON_FIXED_ON = 0 and `mon_en_i` low, `sup_good_i` is ignored. Re-enabling the monitor while the supply is good causes no reset.
- R12: With MON_FIXED_ON = 1, `mon_en_i` is ignored and supply dips always cause reset.
- R13: While reset stays released, `flags_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_i | input | 1 | Synchronous active-high cold-start pulse, treated as a power-type cause |
| sup_good_i | input | 1 | Asynchronous comparator bit, 1 = supply above threshold |
| mon_en_i | input | 1 | Asynchronous monitor enable, 1 = check supply |
| ext_req_i | input | 1 | Asynchronous external reset request, active high |
| wr_en_i | input | 1 | Single-cycle write strobe for the reset-cause register |
| wr_data_i | input | RSRC_W | Write data; only bit 1 acts |
| rst_n_o | output | 1 | Chip reset, active low |
| flags_o | output | RSRC_W | Reset-cause readback: bit 1 power-type, bit 0 external |

## Verification
The assertions assume the following about the inputs:
- `rst_i` is high at time zero.
- Write strobes are synchronous and last one cycle.
- The asynchronous inputs have been through the synchroniser before any property refers to them, so the properties use the synchronised external request and the filtered supply state.

The stimulus changes every input only on the falling clock edge. It holds external requests for at least one full cycle. It changes `mon_en_i` only while no other event is in flight, and it gives each event time to finish its settling interval before the next one starts. Supply pulses are chosen on both sides of the filter length, so the deglitch boundary is exercised without relying on metastable timing.

// File: rtl/smrc_pkg.sv
`timescale 1ns/1ps
package smrc_pkg;

    // Reset-cause register layout: software decodes these positions.
    localparam int RSRC_W  = 8;
    localparam int POR_BIT = 1;
    localparam int EXT_BIT = 0;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic por;
        logic ext;
    } rsrc_flags_t;

    typedef struct packed {
        logic pwr;
        logic ext;
    } cause_t;

    localparam rsrc_flags_t FLAGS_PWR = '{por: 1'b1, ext: 1'b0};
    localparam rsrc_flags_t FLAGS_EXT = '{por: 1'b0, ext: 1'b1};

    // Settling interval in clock cycles; wide arithmetic avoids overflow.
    function automatic longint tmo_cycles(input longint hz, input longint us);
        return (hz * us) / 64'd1000000;
    endfunction

    function automatic logic [RSRC_W-1:0] pack_flags(input rsrc_flags_t f);
        logic [RSRC_W-1:0] v;
        v          = '0;
        v[POR_BIT] = f.por;
        v[EXT_BIT] = f.ext;
        return v;
    endfunction

endpackage

// File: rtl/smrc_sync.sv
`timescale 1ns/1ps
module smrc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stg[g] <= '0;
                else       stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stg[g] <= '0;
                else       stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/smrc_deglitch.sv
`timescale 1ns/1ps
module smrc_deglitch #(
    parameter int LEN = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          q;

    // Output follows the input only after LEN consecutive differing samples.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (d_i == q) begin
            cnt <= '0;
        end else if (cnt == CW'(LEN - 1)) begin
            q   <= d_i;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/smrc_core.sv
`timescale 1ns/1ps
module smrc_core
    import smrc_pkg::*;
#(
    parameter int TMO = 100
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  cause_t      cause_i,
    output ctl_state_e  state_o,
    output rsrc_flags_t flags_o
);
    localparam int CW = $clog2(TMO + 1);

    ctl_state_e    state;
    rsrc_flags_t   flags;
    logic [CW-1:0] cnt;
    logic          pwr_seen;   // current hold contains a power-type cause

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state    <= ST_HOLD;
            cnt      <= '0;
            flags    <= FLAGS_PWR;
            pwr_seen <= 1'b1;
        end else begin
            // Flag update: power-type causes dominate external ones.
            if (cause_i.pwr) begin
                flags    <= FLAGS_PWR;
                pwr_seen <= 1'b1;
            end else if (cause_i.ext && !(state == ST_HOLD && pwr_seen)) begin
                flags    <= FLAGS_EXT;
                pwr_seen <= 1'b0;
            end

            // Hold / settle sequencing: any cause restarts the interval.
            if (cause_i.pwr || cause_i.ext) begin
                state <= ST_HOLD;
                cnt   <= '0;
            end else if (state == ST_HOLD) begin
                if (cnt == CW'(TMO - 1)) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign state_o = state;
    assign flags_o = flags;
endmodule

// File: rtl/smrc_top.sv
`timescale 1ns/1ps
module smrc_top
    import smrc_pkg::*;
#(
    parameter int CLK_HZ       = 24_500_000,
    parameter int TIMEOUT_US   = 100_000,
    parameter int FILT_LEN     = 3,
    parameter int SYNC_STAGES  = 2,
    parameter bit MON_FIXED_ON = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sup_good_i,
    input  logic              mon_en_i,
    input  logic              ext_req_i,
    input  logic              wr_en_i,
    input  logic [RSRC_W-1:0] wr_data_i,
    output logic              rst_n_o,
    output logic [RSRC_W-1:0] flags_o
);
    localparam int TMO = int'(tmo_cycles(longint'(CLK_HZ), longint'(TIMEOUT_US)));

    logic [2:0]  raw_async;
    logic [2:0]  raw_sync;
    logic        sg_q;
    logic        ext_q;
    logic        men_q;
    logic        sg_filt;
    logic        mon_on;
    logic        sup_low;
    logic        sw_force;
    logic        unused_wr;
    cause_t      cause;
    ctl_state_e  state;
    rsrc_flags_t flags;

    assign raw_async = {mon_en_i, ext_req_i, sup_good_i};

    smrc_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_async),
        .q_o   (raw_sync)
    );

    assign sg_q  = raw_sync[0];
    assign ext_q = raw_sync[1];
    assign men_q = raw_sync[2];

    smrc_deglitch #(
        .LEN (FILT_LEN)
    ) u_filt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (sg_q),
        .q_o   (sg_filt)
    );

    // Variant select: a fixed-on monitor ignores the enable pin.
    assign mon_on    = MON_FIXED_ON ? 1'b1 : men_q;
    assign sup_low   = mon_on & ~sg_filt;
    assign sw_force  = wr_en_i & wr_data_i[POR_BIT];
    assign unused_wr = ^wr_data_i;

    assign cause.pwr = sup_low | sw_force;
    assign cause.ext = ext_q;

    smrc_core #(
        .TMO (TMO)
    ) u_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cause_i (cause),
        .state_o (state),
        .flags_o (flags)
    );

    assign rst_n_o = (state == ST_RUN);
    assign flags_o = pack_flags(flags);
endmodule

// File: rtl/smrc_chk.sv
`timescale 1ns/1ps
module smrc_chk
    import smrc_pkg::*;
#(
    parameter int TMO = 100
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rst_n_o,
    input logic [RSRC_W-1:0] flags_o,
    input logic              wr_en_i,
    input logic [RSRC_W-1:0] wr_data_i,
    input logic              ext_q,
    input logic              sup_low
);
    // Consecutive cycles with reset asserted, saturating.
    logic [31:0] low_cnt;
    always_ff @(posedge clk_i) begin
        if (rst_i)               low_cnt <= '0;
        else if (rst_n_o)        low_cnt <= '0;
        else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
    end

    p_release_after_tmo_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> (low_cnt >= 32'(TMO)));

    p_supply_low_holds_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        sup_low |=> (!rst_n_o && flags_o[POR_BIT]));

    p_one_flag_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(flags_o) == 1);

    p_ext_holds_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ext_q |=> !rst_n_o);

    p_sw_force_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_data_i[POR_BIT]) |=>
            (!rst_n_o && flags_o[POR_BIT] && !flags_o[EXT_BIT]));

    p_flags_stable_r13: assert property (@(posedge clk_i) disable iff (rst_i)
        (rst_n_o && $past(rst_n_o)) |-> $stable(flags_o));
endmodule

bind smrc_top smrc_chk #(
    .TMO (TMO)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rst_n_o   (rst_n_o),
    .flags_o   (flags_o),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ext_q     (ext_q),
    .sup_low   (sup_low)
);

// File: tb/smrc_top_test.sv
`timescale 1ns/1ps
module smrc_top_test;
    localparam int CLK_HZ     = 1_000_000;
    localparam int TIMEOUT_US = 40;
    localparam int FILT       = 3;
    localparam int SYNC       = 2;
    localparam int TMO        = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    logic       clk = 1'b0;
    logic       rst, sg, men, ext, wr_en;
    logic [7:0] wr_data;
    logic       rst_n, rst_n_fx;
    logic [7:0] flags, flags_fx;

    always #5 clk = ~clk;

    smrc_top #(
        .CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US), .FILT_LEN(FILT),
        .SYNC_STAGES(SYNC), .MON_FIXED_ON(1'b0)
    ) uut (
        .clk_i(clk), .rst_i(rst), .sup_good_i(sg), .mon_en_i(men),
        .ext_req_i(ext), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rst_n_o(rst_n), .flags_o(flags)
    );

    smrc_top #(
        .CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US), .FILT_LEN(FILT),
        .SYNC_STAGES(SYNC), .MON_FIXED_ON(1'b1)
    ) uut_fixed (
        .clk_i(clk), .rst_i(rst), .sup_good_i(sg), .mon_en_i(men),
        .ext_req_i(ext), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rst_n_o(rst_n_fx), .flags_o(flags_fx)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int   n_chk = 0, n_fail = 0;
    int   fall_cyc = -1, rise_cyc = -1, ffall_cyc = -1, frise_cyc = -1;
    logic prev_rn = 1'b0, prev_fx = 1'b0;
    logic [7:0] exp_flags;

    // Edge recorder: the cycle number is the count of rising edges so far.
    always @(negedge clk) begin
        if (rst_n !== prev_rn) begin
            if (rst_n) rise_cyc = cyc; else fall_cyc = cyc;
        end
        if (rst_n_fx !== prev_fx) begin
            if (rst_n_fx) frise_cyc = cyc; else ffall_cyc = cyc;
        end
        prev_rn = rst_n;
        prev_fx = rst_n_fx;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= 60000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all): actual %0d cycles expected below 60000", cyc);
            finish_run();
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected-value functions derived from the requirements.
    function automatic int fall_sup(input int k);           return k + SYNC + FILT;            endfunction
    function automatic int rise_sup(input int r);           return r + SYNC - 1 + FILT + TMO;  endfunction
    function automatic int fall_ext(input int k);           return k + SYNC;                   endfunction
    function automatic int rise_ext(input int d);           return d + SYNC - 1 + TMO;         endfunction
    function automatic int rise_sw(input int k);            return k + TMO;                    endfunction

    task automatic clr_rec();
        fall_cyc = -1; rise_cyc = -1; ffall_cyc = -1; frise_cyc = -1;
    endtask

    task automatic wait_rise(input int limit);
        for (int i = 0; i < limit && rise_cyc < 0; i++) begin
            @(negedge clk); #1;
        end
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic check_ev(input string req, input int efall, input int erise, input logic [7:0] ef);
        chk_eq(req, "reset fall cycle", fall_cyc, efall);
        chk_eq(req, "reset rise cycle", rise_cyc, erise);
        chk_eq(req, "flags after release", int'(flags), int'(ef));
        exp_flags = ef;
    endtask

    task automatic check_quiet(input string req);
        chk_eq(req, "no reset fall", fall_cyc, -1);
        chk_eq(req, "reset stays released", int'(rst_n), 1);
        chk_eq(req, "flags unchanged", int'(flags), int'(exp_flags));
    endtask

    // Called right after a falling edge: write is sampled at the next rising edge.
    task automatic pulse_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    // kind 0: software force, 1: external request, 2: supply dip, 3: benign write
    task automatic run_event(input int kind, input int len, input string req);
        int k;
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        case (kind)
            0: begin
                pulse_write(8'($urandom) | 8'h02);
                wait_rise(TMO + 20);
                check_ev(req, k, rise_sw(k), 8'h02);
            end
            1: begin
                ext = 1'b1;
                repeat (len) @(negedge clk);
                ext = 1'b0;
                wait_rise(TMO + 20);
                check_ev(req, fall_ext(k), rise_ext(k + len), 8'h01);
            end
            2: begin
                sg = 1'b0;
                repeat (len) @(negedge clk);
                sg = 1'b1;
                if (len >= FILT) begin
                    wait_rise(TMO + 20);
                    check_ev(req, fall_sup(k), rise_sup(k + len), 8'h02);
                end else begin
                    repeat (SYNC + FILT + 4) @(negedge clk);
                    #1;
                    check_quiet(req);
                end
            end
            default: begin
                pulse_write(8'($urandom) & 8'hFD);
                repeat (SYNC + FILT + 4) @(negedge clk);
                #1;
                check_quiet(req);
            end
        endcase
    endtask

    initial begin
        int k, k2;
        void'($urandom(32'd20240611));
        rst = 1'b1; sg = 1'b1; men = 1'b1; ext = 1'b0; wr_en = 1'b0; wr_data = 8'h00;

        // R1: cold-start state
        repeat (4) @(negedge clk);
        #1;
        chk_eq("R1", "rst_n during cold start", int'(rst_n), 0);
        chk_eq("R1", "flags during cold start", int'(flags), 8'h02);
        chk_eq("R1", "fixed variant rst_n during cold start", int'(rst_n_fx), 0);

        // R2/R6: release after cold start with supply already good
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        rst = 1'b0;
        wait_rise(TMO + 30);
        chk_eq("R2", "cold-start release cycle", rise_cyc, k + SYNC - 1 + FILT + TMO);
        chk_eq("R6", "power flag after cold start", int'(flags), 8'h02);
        exp_flags = 8'h02;

        // Directed cases
        run_event(3, 0, "R9");
        run_event(0, 0, "R8");
        run_event(1, 5, "R7");
        run_event(2, FILT - 1, "R4");
        chk_eq("R13", "flags steady while released", int'(flags), int'(exp_flags));
        run_event(2, FILT, "R3");
        chk_eq("R6", "dip sets power flag only", int'(flags), 8'h02);

        // R5: supply dip during the settling interval restarts the count
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        pulse_write(8'h02);
        repeat (19) @(negedge clk);
        k2 = cyc + 1;
        sg = 1'b0;
        repeat (4) @(negedge clk);
        sg = 1'b1;
        wait_rise(TMO + 30);
        check_ev("R5", k, rise_sup(k2 + 4), 8'h02);

        // R10: external request during a power-type hold keeps flags at 0x02
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        pulse_write(8'h02);
        repeat (4) @(negedge clk);
        k2 = cyc + 1;
        ext = 1'b1;
        repeat (6) @(negedge clk);
        ext = 1'b0;
        wait_rise(TMO + 30);
        check_ev("R10", k, rise_ext(k2 + 6), 8'h02);

        // R10: power-type cause during an external hold switches flags to 0x02
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        ext = 1'b1;
        repeat (10) @(negedge clk);
        pulse_write(8'h02);
        repeat (19) @(negedge clk);
        ext = 1'b0;
        wait_rise(TMO + 30);
        check_ev("R10", fall_ext(k), rise_ext(k + 30), 8'h02);

        // R11/R12: monitor disabled on the pin
        men = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        clr_rec();
        @(negedge clk);
        k = cyc + 1;
        sg = 1'b0;
        repeat (20) @(negedge clk);
        sg = 1'b1;
        repeat (SYNC + FILT + 4) @(negedge clk);
        #1;
        check_quiet("R11");
        chk_eq("R12", "fixed variant fall cycle", ffall_cyc, fall_sup(k));
        for (int i = 0; i < TMO + 20 && frise_cyc < 0; i++) begin
            @(negedge clk); #1;
        end
        chk_eq("R12", "fixed variant rise cycle", frise_cyc, rise_sup(k + 20));
        clr_rec();
        men = 1'b1;
        repeat (SYNC + FILT + 4) @(negedge clk);
        #1;
        check_quiet("R11");

        // Constrained random sequence
        for (int n = 0; n < 24; n++) begin
            int kind;
            int len;
            kind = int'($urandom_range(3, 0));
            case (kind)
                1:       len = int'($urandom_range(20, 1));
                2:       len = (($urandom & 1) != 0) ? int'($urandom_range(20, FILT))
                                                     : int'($urandom_range(FILT - 1, 1));
                default: len = 0;
            endcase
            case (kind)
                0:       run_event(kind, len, "R8");
                1:       run_event(kind, len, "R7");
                2:       run_event(kind, len, (len >= FILT) ? "R3" : "R4");
                default: run_event(kind, len, "R9");
            endcase
        end

        finish_run();
    end
endmodule